// File: doc/BRIEF.md
# Receive Cell Port with Cell-Available Handshake

This block is the receive half of an ATM cell-transfer port. It faces a layer processor that reads cells. A framer on the write side hands over one byte per cycle, and each cell's first byte carries a start-of-cell marker. The bytes land in an internal FIFO that is sized in whole 53-byte cells. The reader pulls bytes with an active-low read enable. It gets back an 8-bit data bus and a start-of-cell flag, and it watches a cell-available flag to decide when to read.

The cell-available flag has three behaviours, chosen by a static mode input:

- It can report that any byte is present.
- It can report that at least one complete cell is present.
- In the multi-PHY variant, it is only driven while the local port address was presented on the 5-bit address bus in the previous cycle. In that case it follows the complete-cell rule.

Bus drivers are modelled with explicit output-enable signals rather than tri-state nets. Admission is decided per cell. When a new cell starts and the FIFO cannot take all 53 of its bytes, the whole cell is discarded and a sticky flag records that a cell was dropped. Both sides run on one clock.

Top module: `urx_rx_port`

## Requirements
- R1: With mode code 2'b00 (byte handshake), `clav` is high exactly when the FIFO holds at least one byte, and `clav_oe` is high.
- R2: With mode code 2'b01, and with the unused code 2'b11 treated the same way, `clav_oe` is high. `clav` is high exactly when the FIFO holds a complete cell whose first byte has not yet been read.
- R3: With mode code 2'b10 (multi-PHY), `clav_oe` is high in a cycle only if `rd_addr` equalled `cfg_addr` at the previous clock edge. While `clav_oe` is high, `clav` follows the R2 rule; while it is low, `clav` is low.
- R4: `rd_data_oe` is the inverse of `rd_en_n`. While `rd_en_n` is high, nothing is read and `rd_data`/`rd_soc` keep their values.
- R5: When `rd_en_n` is low at a clock edge and the FIFO is not empty, the oldest byte is removed and appears on `rd_data` after that edge. Bytes come out in write order.
- R6: `rd_soc` is high together with the first byte of a cell on `rd_data`, and low with every other byte.
- R7: The FIFO holds 4 cells (212 bytes). A byte written with `wr_soc` high starts a new cell. That cell is accepted only if at least 53 bytes are free, counted before any read in the same cycle. Otherwise all 53 bytes of the cell are discarded and `overflow_seen` goes high and stays high until reset.
- R8: A read request while the FIFO is empty is ignored. `rd_data` and `rd_soc` keep their values.
- R9: While `rst_n` is low at a clock edge, the FIFO empties, `rd_data` becomes 0, and `rd_soc`, `overflow_seen` and `clav` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for write and read sides |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Handshake mode: 00 byte, 01 cell, 10 multi-PHY, 11 as cell |
| cfg_addr | input | 5 | Local port address for multi-PHY polling |
| wr_valid | input | 1 | Write byte valid from the framer |
| wr_data | input | 8 | Write byte |
| wr_soc | input | 1 | Write byte is the first of a cell |
| rd_en_n | input | 1 | Active-low read enable |
| rd_addr | input | 5 | Polled port address |
| rd_data | output | 8 | Read data bus |
| rd_data_oe | output | 1 | Drive enable for the read data bus |
| rd_soc | output | 1 | First byte of a cell is on `rd_data` |
| clav | output | 1 | Cell/byte available |
| clav_oe | output | 1 | Drive enable for `clav` |
| overflow_seen | output | 1 | Sticky: a cell was discarded for lack of room |

## Verification
The bench builds the block with its default parameters: 53-byte cells and a 4-cell FIFO. With those values a burst of five cells written without reads runs into the exact boundary where the fifth cell is dropped. Random phases cover all four mode codes. In each phase the read rate varies, which drives the FIFO between empty, partly filled cells and full. Addresses match the local address about a third of the time, so multi-PHY selection switches on and off often. A drain followed by reads on an empty FIFO exercises the hold-on-empty rule.

// File: rtl/urx_pkg.sv
// Package: shared types for the receive cell port.
// Assumes: mode codes are a static configuration input.
package urx_pkg;
    typedef enum logic [1:0] {
        HS_OCTET = 2'b00,
        HS_CELL  = 2'b01,
        HS_MPHY  = 2'b10,
        HS_RSVD  = 2'b11
    } hs_mode_e;
endpackage

// File: rtl/urx_store.sv
// Module: circular byte store with a start-of-cell tag per entry.
// What it does: holds DEPTH tagged bytes. It exposes the head entry and a byte count.
// Assumes: the caller never pushes into a full store (admission reserves room).
//          A pop request on an empty store is dropped here.
module urx_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 212,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_soc,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head_data,
    output logic              head_soc,
    output logic              popped,
    output logic [CNT_W-1:0]  byte_cnt
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W:0]    mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign popped = pop_req && (byte_cnt != '0);
    assign {head_soc, head_data} = mem[rd_ptr];

    // Storage write: tagged byte goes to the write slot.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= {push_soc, push_data};
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            byte_cnt <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (popped) rd_ptr <= bump(rd_ptr);
            case ({push, popped})
                2'b10:   byte_cnt <= byte_cnt + 1'b1;
                2'b01:   byte_cnt <= byte_cnt - 1'b1;
                default: byte_cnt <= byte_cnt;
            endcase
        end
    end
endmodule

// File: rtl/urx_admit.sv
// Module: per-cell admission on the write side.
// What it does: at each start-of-cell byte, decides whether the whole cell fits.
//   An accepted cell's bytes are pushed. A rejected cell is skipped and a sticky flag is set.
// Assumes: CELL_BYTES > 1. Bytes beyond CELL_BYTES in one cell are discarded.
module urx_admit #(
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 212,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_soc,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic             push,
    output logic             cell_start,
    output logic             cell_done,
    output logic             ovf_flag
);
    localparam int BIN_W = $clog2(CELL_BYTES + 1);

    logic             accepting;
    logic [BIN_W-1:0] bytes_in;
    logic             room;

    assign room       = byte_cnt <= CNT_W'(DEPTH - CELL_BYTES);
    assign cell_start = wr_valid && wr_soc && room;
    assign push       = cell_start || (wr_valid && !wr_soc && accepting);
    assign cell_done  = push && !wr_soc && (bytes_in == BIN_W'(CELL_BYTES - 1));

    // Cell tracking: acceptance state, byte position, sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accepting <= 1'b0;
            bytes_in  <= '0;
            ovf_flag  <= 1'b0;
        end else if (wr_valid && wr_soc) begin
            accepting <= room;
            bytes_in  <= BIN_W'(1);
            if (!room) ovf_flag <= 1'b1;
        end else if (push) begin
            bytes_in <= bytes_in + 1'b1;
            if (cell_done) accepting <= 1'b0;
        end
    end
endmodule

// File: rtl/urx_cellcnt.sv
// Module: count of complete cells whose first byte is still stored.
// What it does: counts up when a cell completes and down when a complete cell's
//   first byte is read. If the reader takes the head of a cell that is still
//   being written, that cell is never counted.
// Assumes: complete cells are always older than the cell being written.
module urx_cellcnt #(
    parameter int CCNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_start,
    input  logic cell_done,
    input  logic pop_soc,
    output logic have_cell
);
    logic [CCNT_W-1:0] cells;
    logic              head_gone;
    logic              early_pop;
    logic              inc;
    logic              dec;

    assign early_pop = pop_soc && (cells == '0);
    assign inc       = cell_done && !head_gone && !early_pop;
    assign dec       = pop_soc && (cells != '0);
    assign have_cell = cells != '0;

    // Complete-cell counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (inc && !dec) begin
            cells <= cells + 1'b1;
        end else if (dec && !inc) begin
            cells <= cells - 1'b1;
        end
    end

    // Marks an in-progress cell whose first byte was already read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_gone <= 1'b0;
        end else if (cell_start) begin
            head_gone <= 1'b0;
        end else if (early_pop) begin
            head_gone <= 1'b1;
        end
    end
endmodule

// File: rtl/urx_handshake.sv
// Module: cell-available flag and its drive enable.
// What it does: picks the byte or cell rule by mode. In multi-PHY mode it drives
//   only in the cycle after the polled address matched the local address.
// Assumes: mode and local address are static.
module urx_handshake
    import urx_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_mode_e          mode,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic              any_byte,
    input  logic              have_cell,
    output logic              clav,
    output logic              clav_oe
);
    logic sel_q;

    // Registers the address match for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= (poll_addr == local_addr);
        end
    end

    // Flag and enable by mode.
    always_comb begin
        case (mode)
            HS_OCTET: begin
                clav_oe = 1'b1;
                clav    = any_byte;
            end
            HS_MPHY: begin
                clav_oe = sel_q;
                clav    = sel_q && have_cell;
            end
            default: begin
                clav_oe = 1'b1;
                clav    = have_cell;
            end
        endcase
    end
endmodule

// File: rtl/urx_rx_port.sv
// Module: top of the receive cell port.
// What it does: joins admission, storage, cell counting and handshake. It registers
//   the read data and start-of-cell flag on each successful read.
// Assumes: one clock for both sides; cfg_mode and cfg_addr are static.
module urx_rx_port
    import urx_pkg::*;
#(
    parameter int CELL_BYTES  = 53,
    parameter int DEPTH_CELLS = 4,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_soc,
    input  logic              rd_en_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_oe,
    output logic              rd_soc,
    output logic              clav,
    output logic              clav_oe,
    output logic              overflow_seen
);
    localparam int DEPTH  = CELL_BYTES * DEPTH_CELLS;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int CCNT_W = $clog2(DEPTH_CELLS + 1);

    logic              push;
    logic              cell_start;
    logic              cell_done;
    logic              popped;
    logic              head_soc;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  byte_cnt;
    logic              have_cell;

    urx_admit #(
        .CELL_BYTES (CELL_BYTES),
        .DEPTH      (DEPTH),
        .CNT_W      (CNT_W)
    ) admit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_soc     (wr_soc),
        .byte_cnt   (byte_cnt),
        .push       (push),
        .cell_start (cell_start),
        .cell_done  (cell_done),
        .ovf_flag   (overflow_seen)
    );

    urx_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .push_soc  (wr_soc),
        .pop_req   (!rd_en_n),
        .head_data (head_data),
        .head_soc  (head_soc),
        .popped    (popped),
        .byte_cnt  (byte_cnt)
    );

    urx_cellcnt #(
        .CCNT_W (CCNT_W)
    ) cellcnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .cell_done  (cell_done),
        .pop_soc    (popped && head_soc),
        .have_cell  (have_cell)
    );

    urx_handshake #(
        .ADDR_W (ADDR_W)
    ) hs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (hs_mode_e'(cfg_mode)),
        .local_addr (cfg_addr),
        .poll_addr  (rd_addr),
        .any_byte   (byte_cnt != '0),
        .have_cell  (have_cell),
        .clav       (clav),
        .clav_oe    (clav_oe)
    );

    assign rd_data_oe = !rd_en_n;

    // Read output register: loads the head byte on a successful read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_soc  <= 1'b0;
        end else if (popped) begin
            rd_data <= head_data;
            rd_soc  <= head_soc;
        end
    end
endmodule

// File: rtl/urx_rx_port_chk.sv
// Module: property checker for the receive cell port, bound to the top.
// Assumes: cfg_mode and cfg_addr are static between resets.
module urx_rx_port_chk
    import urx_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 212,
    parameter int CNT_W      = 8,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              rd_en_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_soc,
    input logic              clav,
    input logic              clav_oe,
    input logic              overflow_seen,
    input logic [CNT_W-1:0]  byte_cnt
);
    a_r1_octet_clav: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == HS_OCTET) |-> (clav == (byte_cnt != '0)));

    a_r2_cell_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != HS_OCTET && byte_cnt < CNT_W'(CELL_BYTES)) |-> !clav);

    a_r3_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == HS_MPHY && rd_addr != cfg_addr) |=> !clav_oe);

    a_r3_selected_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == HS_MPHY && rd_addr == cfg_addr) |=> clav_oe);

    a_r3_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
        !clav_oe |-> !clav);

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |=> ($stable(rd_data) && $stable(rd_soc)));

    a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(DEPTH));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_seen |=> overflow_seen);

    a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_n && byte_cnt == '0) |=> ($stable(rd_data) && $stable(rd_soc)));
endmodule

bind urx_rx_port urx_rx_port_chk #(
    .CELL_BYTES (CELL_BYTES),
    .DEPTH      (DEPTH),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_addr      (cfg_addr),
    .rd_en_n       (rd_en_n),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .rd_soc        (rd_soc),
    .clav          (clav),
    .clav_oe       (clav_oe),
    .overflow_seen (overflow_seen),
    .byte_cnt      (byte_cnt)
);

// File: tb/urx_rx_port_tb_top.sv
`timescale 1ns/1ps
// Bench: random and directed stimulus for the receive cell port. Every output is
// compared each cycle against a queue-based model built from the requirements.
module urx_rx_port_tb_top;
    localparam int CELL  = 53;
    localparam int CELLS = 4;
    localparam int DEPTH = CELL * CELLS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [4:0] cfg_addr = 5'd9;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_soc = 1'b0;
    logic       rd_en_n = 1'b1;
    logic [4:0] rd_addr = 5'd0;
    logic [7:0] rd_data;
    logic       rd_data_oe, rd_soc, clav, clav_oe, overflow_seen;

    int total = 0;
    int bad   = 0;

    // Model state
    byte unsigned q_d[$];
    bit           q_s[$];
    int           q_c[$];
    bit           done_c[int];
    int           cur_cid = 0;
    bit           m_acc = 0;
    int           m_cnt = 0;
    bit           m_ovf = 0;
    bit           m_sel = 0;
    byte unsigned m_data = 0;
    bit           m_soc = 0;
    int           gen_left = 0;

    urx_rx_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_addr(cfg_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_soc(wr_soc),
        .rd_en_n(rd_en_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_data_oe(rd_data_oe), .rd_soc(rd_soc), .clav(clav),
        .clav_oe(clav_oe), .overflow_seen(overflow_seen)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit cell_present();
        foreach (q_s[i]) if (q_s[i] && done_c.exists(q_c[i])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void model_clear();
        q_d.delete(); q_s.delete(); q_c.delete(); done_c.delete();
        m_acc = 0; m_cnt = 0; m_ovf = 0; m_sel = 0; m_data = 0; m_soc = 0;
        gen_left = 0;
    endfunction

    // Model update for one clock edge, using the inputs driven for that edge.
    function automatic void model_edge();
        int pre = q_d.size();
        if (!rd_en_n && pre > 0) begin
            m_data = q_d.pop_front();
            m_soc  = q_s.pop_front();
            void'(q_c.pop_front());
        end
        if (wr_valid && wr_soc) begin
            if (DEPTH - pre >= CELL) begin
                cur_cid++; m_acc = 1; m_cnt = 1;
                q_d.push_back(wr_data); q_s.push_back(1'b1); q_c.push_back(cur_cid);
            end else begin
                m_acc = 0; m_ovf = 1;
            end
        end else if (wr_valid && m_acc) begin
            q_d.push_back(wr_data); q_s.push_back(1'b0); q_c.push_back(cur_cid);
            m_cnt++;
        end
        if (m_acc && m_cnt == CELL) begin
            done_c[cur_cid] = 1'b1;
            m_acc = 0;
        end
        m_sel = (rd_addr == cfg_addr);
    endfunction

    task automatic check_outputs();
        bit cp = cell_present();
        case (cfg_mode)
            2'b00: begin
                chk("R1", "clav", int'(clav), int'(q_d.size() > 0));
                chk("R1", "clav_oe", int'(clav_oe), 1);
            end
            2'b10: begin
                chk("R3", "clav_oe", int'(clav_oe), int'(m_sel));
                chk("R3", "clav", int'(clav), int'(m_sel && cp));
            end
            default: begin
                chk("R2", "clav", int'(clav), int'(cp));
                chk("R2", "clav_oe", int'(clav_oe), 1);
            end
        endcase
        chk("R4", "rd_data_oe", int'(rd_data_oe), int'(!rd_en_n));
        chk("R5", "rd_data", int'(rd_data), int'(m_data));
        chk("R6", "rd_soc", int'(rd_soc), int'(m_soc));
        chk("R7", "overflow_seen", int'(overflow_seen), int'(m_ovf));
    endtask

    // One cycle: edge, model, check just after the edge, return at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        check_outputs();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        rst_n = 1'b0; cfg_mode = mode;
        wr_valid = 1'b0; wr_soc = 1'b0; rd_en_n = 1'b1; rd_addr = 5'd0;
        repeat (2) @(posedge clk);
        #1;
        model_clear();
        chk("R9", "reset clav", int'(clav), 0);
        chk("R9", "reset rd_data", int'(rd_data), 0);
        chk("R9", "reset rd_soc", int'(rd_soc), 0);
        chk("R9", "reset overflow", int'(overflow_seen), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives the next write byte of a cell stream (start new cell when asked).
    task automatic drive_write(input bit want_new, input int pct);
        if (gen_left == 0 && want_new) gen_left = CELL;
        if (gen_left > 0 && ($urandom % 100) < pct) begin
            wr_valid = 1'b1;
            wr_soc   = (gen_left == CELL);
            wr_data  = 8'($urandom);
            gen_left--;
        end else begin
            wr_valid = 1'b0;
            wr_soc   = 1'b0;
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        byte unsigned held;
        void'($urandom(32'd2024));

        // Directed: cell mode, five back-to-back cells with no reads; the fifth is dropped (R7).
        do_reset(2'b01);
        for (int c = 0; c < 5; c++) begin
            for (int b = 0; b < CELL; b++) begin
                wr_valid = 1'b1; wr_soc = (b == 0); wr_data = 8'(c * 16 + b);
                tick();
            end
        end
        wr_valid = 1'b0; wr_soc = 1'b0;
        tick();
        chk("R7", "stored bytes after burst", q_d.size(), DEPTH);
        // Drain all bytes in order (R5, R6), then read on empty (R8).
        rd_en_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) tick();
        held = m_data;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8", "empty read keeps data", int'(rd_data), int'(held));
            chk("R8", "empty read keeps soc", int'(rd_soc), 0);
        end
        rd_en_n = 1'b1;
        tick();

        // Directed: byte mode, a single byte raises the flag (R1).
        do_reset(2'b00);
        wr_valid = 1'b1; wr_soc = 1'b1; wr_data = 8'hA5;
        tick();
        wr_valid = 1'b0; wr_soc = 1'b0;
        chk("R1", "clav after one byte", int'(clav), 1);
        rd_en_n = 1'b0;
        tick();
        chk("R5", "first byte read", int'(rd_data), 8'hA5);
        chk("R6", "first byte soc", int'(rd_soc), 1);
        rd_en_n = 1'b1;

        // Random phases across all mode codes and read rates.
        for (int m = 0; m < 4; m++) begin
            for (int phase = 0; phase < 3; phase++) begin
                int rd_pct = (phase == 0) ? 10 : (phase == 1) ? 50 : 90;
                do_reset(2'(m));
                cfg_addr = 5'($urandom);
                for (int cyc = 0; cyc < 2500; cyc++) begin
                    drive_write(($urandom % 6) == 0, 80);
                    rd_en_n = (($urandom % 100) >= rd_pct);
                    rd_addr = (($urandom % 3) == 0) ? cfg_addr : 5'($urandom);
                    tick();
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule